// File: doc/BRIEF.md
# Hysteretic Level Trigger

This block watches a stream of signed 16-bit samples. It emits a one-clock trigger pulse when the signal crosses a programmable threshold in the selected direction. After it fires, the block disarms. It re-arms only when a later sample has moved past the threshold, by a programmable hysteresis margin, on the side opposite the crossing. A noisy signal that hovers around the threshold therefore produces one trigger and not a burst.

The two band limits are threshold minus hysteresis and threshold plus hysteresis. Both are computed with saturation, so they never wrap. Crossing detection needs no copy of the previous sample. The armed state alone records that the last accepted sample lay on the far side of the threshold. An enable input lets the surrounding acquisition logic hold the trigger quiet.

Top module: `hyst_trig`

## Requirements
- R1: While reset is asserted, and after it is released, `trig_o` and `armed_o` are 0.
- R2: In rising mode (`edge_fall_i`=0), a valid sample accepted while armed that is greater than or equal to the threshold raises `trig_o` for the following cycle and clears `armed_o`.
- R3: After a rising trigger, no further trigger occurs until a valid sample strictly below saturated(threshold − hysteresis) has re-armed the block.
- R4: In falling mode (`edge_fall_i`=1), a valid sample accepted while armed that is strictly below the threshold raises `trig_o` for the following cycle and clears `armed_o`.
- R5: In falling mode, re-arming needs a valid sample strictly above saturated(threshold + hysteresis).
- R6: Cycles with `smp_vld_i`=0 leave `armed_o` unchanged and produce no pulse, whatever the sample value.
- R7: The block leaves reset disarmed and arms on the first valid sample that lies on the re-arm side of the band. `armed_o` rises in the cycle after that sample.
- R8: The band limits saturate at −32768 and +32767. Samples are two's complement and `hyst_i` is unsigned. A limit that would overflow does not wrap around to the other side.
- R9: While `enable_i`=0, `armed_o` is 0 in the following cycle and no pulse is produced.
- R10: `trig_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Trigger enable; 0 disarms the block |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 16 | Sample, two's complement |
| thresh_i | input | 16 | Threshold, two's complement |
| hyst_i | input | 16 | Hysteresis margin, unsigned |
| edge_fall_i | input | 1 | 0 selects rising mode, 1 selects falling mode |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | 1 while a crossing would fire |

## Verification
The bench presents a sample exactly at the threshold and exactly at each band limit. A design with an off-by-one comparison would fire one step late, or re-arm too early, in those cases. Samples that wobble just around the threshold after a fire catch a design that re-arms without the hysteresis, because it would emit extra pulses. Thresholds near both ends of the range, combined with a wide hysteresis, expose band arithmetic that wraps: such a design arms on an ordinary mid-scale sample. Other vectors carry an out-of-range sample while the strobe is low, and drop the enable while the block is armed. These catch designs that act on invalid samples or keep their armed state across a disable.

// File: rtl/hyst_trig_pkg.sv
package hyst_trig_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/hyst_band.sv
// Saturating band limits around the threshold.
module hyst_band #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] thr_i,
  input  logic        [W-1:0] hyst_i,
  output logic signed [W-1:0] lo_o,
  output logic signed [W-1:0] hi_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAX_X = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] MIN_X = {3'b111, {(W-1){1'b0}}};

  logic signed [XW-1:0] thr_x, hyst_x, lo_x, hi_x;

  always_comb begin
    thr_x  = {{2{thr_i[W-1]}}, thr_i};
    hyst_x = {2'b00, hyst_i};
    lo_x   = thr_x - hyst_x;
    hi_x   = thr_x + hyst_x;
    lo_o   = (lo_x < MIN_X) ? MIN_X[W-1:0] : lo_x[W-1:0];
    hi_o   = (hi_x > MAX_X) ? MAX_X[W-1:0] : hi_x[W-1:0];
  end

  always_comb begin
    AST_BAND_ORDER: assert (lo_o <= thr_i && hi_o >= thr_i); // R8
  end
endmodule

// File: rtl/hyst_cmp.sv
// Per-sample crossing and re-arm conditions for the selected direction.
module hyst_cmp
  import hyst_trig_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] smp_i,
  input  logic signed [W-1:0] thr_i,
  input  logic signed [W-1:0] lo_i,
  input  logic signed [W-1:0] hi_i,
  input  edge_e               edge_i,
  output logic                hit_o,
  output logic                rearm_o
);
  always_comb begin
    unique case (edge_i)
      EDGE_RISE: begin
        hit_o   = (smp_i >= thr_i);
        rearm_o = (smp_i <  lo_i);
      end
      EDGE_FALL: begin
        hit_o   = (smp_i <  thr_i);
        rearm_o = (smp_i >  hi_i);
      end
      default: begin
        hit_o   = 1'b0;
        rearm_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hyst_arm_ctl.sv
// Armed state and registered trigger pulse.
module hyst_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic vld_i,
  input  logic hit_i,
  input  logic rearm_i,
  output logic armed_o,
  output logic trig_o
);
  logic armed_q, armed_d;
  logic trig_q, trig_d;
  logic accept;

  always_comb begin
    accept  = en_i & vld_i;
    armed_d = armed_q;
    trig_d  = 1'b0;
    if (!en_i) begin
      armed_d = 1'b0;
    end else if (accept) begin
      if (armed_q && hit_i) begin
        trig_d  = 1'b1;
        armed_d = 1'b0;
      end else if (!armed_q && rearm_i) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= trig_d;
    end
  end

  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  AST_FIRE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vld_i && armed_q && hit_i) |=> trig_q); // R2
  AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> !armed_q); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !vld_i) |=> ($stable(armed_q) && !trig_q)); // R6
  AST_ARM_ON_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vld_i && !armed_q && rearm_i) |=> armed_q); // R7
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!armed_q && !trig_q)); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q); // R10
endmodule

// File: rtl/hyst_trig.sv
module hyst_trig
  import hyst_trig_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] thresh_i,
  input  logic [SMP_W-1:0] hyst_i,
  input  logic             edge_fall_i,
  output logic             trig_o,
  output logic             armed_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic signed [SMP_W-1:0] smp_s, thr_s, lo_lim, hi_lim;
  logic hit, rearm;
  edge_e edge_sel;

  assign smp_s    = $signed(smp_i);
  assign thr_s    = $signed(thresh_i);
  assign edge_sel = edge_e'(edge_fall_i);

  hyst_band #(.W(SMP_W)) u_band (
    .thr_i (thr_s),
    .hyst_i(hyst_i),
    .lo_o  (lo_lim),
    .hi_o  (hi_lim)
  );

  hyst_cmp #(.W(SMP_W)) u_cmp (
    .smp_i  (smp_s),
    .thr_i  (thr_s),
    .lo_i   (lo_lim),
    .hi_i   (hi_lim),
    .edge_i (edge_sel),
    .hit_o  (hit),
    .rearm_o(rearm)
  );

  hyst_arm_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (enable_i),
    .vld_i  (smp_vld_i),
    .hit_i  (hit),
    .rearm_i(rearm),
    .armed_o(armed_o),
    .trig_o (trig_o)
  );
endmodule

// File: tb/sim_hyst_trig.sv
module sim_hyst_trig;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        en;
    logic        vld;
    logic        fall;
    logic [15:0] thr;
    logic [15:0] hys;
    logic [15:0] smp;
    logic        x_trig;
    logic        x_arm;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd90,  1'b0,1'b0}, // R7 inside band, stays disarmed
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd150, 1'b0,1'b0}, // R7 above threshold while disarmed
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd79,  1'b0,1'b1}, // R7 below 80 arms
    '{1'b1,1'b0,1'b0, 16'd100, 16'd20, 16'd200, 1'b0,1'b1}, // R6 invalid strobe ignored
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd99,  1'b0,1'b1}, // R2 just under threshold
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd100, 1'b1,1'b0}, // R2 fires at threshold
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd99,  1'b0,1'b0}, // R3 noise below
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd101, 1'b0,1'b0}, // R3 noise above, no pulse
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd80,  1'b0,1'b0}, // R3 at lower limit, no re-arm
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd79,  1'b0,1'b1}, // R3 below lower limit re-arms
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd500, 1'b1,1'b0}, // R2 large step fires
    '{1'b1,1'b1,1'b0, 16'd100, 16'd20, 16'd500, 1'b0,1'b0}, // R10 pulse lasts one cycle
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd20, 1'b0,1'b0}, // R5 at upper limit, no arm
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd19, 1'b0,1'b1}, // R5 above upper limit arms
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd50, 1'b0,1'b1}, // R4 equal to threshold, no fire
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd51, 1'b1,1'b0}, // R4 below threshold fires
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd10, 1'b0,1'b1}, // R5 re-arm after fire
    '{1'b0,1'b1,1'b1, -16'sd50, 16'd30, -16'sd100,1'b0,1'b0}, // R9 disabled, no pulse, disarmed
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, -16'sd100,1'b0,1'b0}, // R9 re-enabled, stays disarmed
    '{1'b1,1'b1,1'b1, -16'sd50, 16'd30, 16'd0,   1'b0,1'b1}, // R5 arms again
    '{1'b0,1'b0,1'b1, -16'sd50, 16'd30, 16'd0,   1'b0,1'b0}, // R9 disable clears armed
    '{1'b1,1'b1,1'b0, -16'sd32700, 16'd1000, 16'd0, 1'b0,1'b0},        // R8 low limit clamps
    '{1'b1,1'b1,1'b0, -16'sd32700, 16'd1000, 16'h8000, 1'b0,1'b0},     // R8 min sample cannot arm
    '{1'b1,1'b1,1'b1, 16'sd32700, 16'd1000, 16'd0, 1'b0,1'b0},         // R8 high limit clamps
    '{1'b1,1'b1,1'b1, 16'sd32700, 16'd1000, 16'h7FFF, 1'b0,1'b0}       // R8 max sample cannot arm
  };

  logic clk, rst_n, enable_i, smp_vld_i, edge_fall_i, trig_o, armed_o;
  logic [15:0] smp_i, thresh_i, hyst_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  hyst_trig u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .smp_vld_i(smp_vld_i),
    .smp_i(smp_i), .thresh_i(thresh_i), .hyst_i(hyst_i), .edge_fall_i(edge_fall_i),
    .trig_o(trig_o), .armed_o(armed_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    enable_i    = v.en;
    smp_vld_i   = v.vld;
    edge_fall_i = v.fall;
    thresh_i    = v.thr;
    hyst_i      = v.hys;
    smp_i       = v.smp;
  endtask

  initial begin
    rst_n = 1'b0;
    apply('0);
    repeat (3) @(negedge clk);
    check("R1", "trig in reset", trig_o, 1'b0);
    check("R1", "armed in reset", armed_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "trig after release", trig_o, 1'b0);
    check("R1", "armed after release", armed_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("vec%0d", i), "trig", trig_o, VEC[i].x_trig);
      check($sformatf("vec%0d", i), "armed", armed_o, VEC[i].x_arm);
    end

    // R1: reset while armed clears state
    apply(VEC[2]);
    @(negedge clk);
    check("R7", "armed before reset", armed_o, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1", "armed cleared by reset", armed_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(VEC[5]);
    repeat (3) @(negedge clk);
    check("R1", "no pulse after reset", trig_o, 1'b0);
    check("R1", "disarmed after reset", armed_o, 1'b0);

    // R9: enable low while a crossing sample is presented
    apply(VEC[2]);
    @(negedge clk);
    enable_i = 1'b0;
    smp_i = 16'd300;
    @(negedge clk);
    check("R9", "no pulse while disabled", trig_o, 1'b0);
    check("R9", "disarmed while disabled", armed_o, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule